// File: doc/BRIEF.md
# Routine Start Arbiter

This block decides when each of six stored micro-routines begins execution, and when the host may use the shared content-addressable memory directly. Two routines belong to a frame-watching bridge unit. Routine 0 compares addresses and is armed by the arrival of a frame's start delimiter, either at once or after a programmable number of clock cycles. Routine 1 learns addresses and is armed by the error indicator in the frame status field. Each of the two bridge routines has its own enable. The four remaining routines, numbered 2 to 5, can only be requested by the host.

Every request is latched as pending until the arbiter serves it. While no routine runs, the lowest-numbered pending routine wins. Routines 0 and 1 therefore come before the host routines, and a direct host memory access comes last of all. A grant sets a busy flag and gives a one-cycle start strobe, together with the routine number and that routine's entry address, which is taken from a per-routine start address register. The execution engine clears the busy state with a done pulse. A running routine cannot be preempted. A direct memory access is granted with a single-cycle strobe.

Top module: `routine_start_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, busy, start_pulse and cam_gnt are 0, run_id is 0 and run_addr is 0.
- R2: With bridge_en0 high and sd_delay 0, a one-cycle sd_seen pulse produces start_pulse with run_id 0 one cycle after the edge that samples it.
- R3: With a nonzero sd_delay of D, the routine 0 start is D cycles later than with a delay of 0. A new sd_seen that arrives while the count is running restarts the count from D.
- R4: An sd_seen with bridge_en0 low, or an fs_err_seen with bridge_en1 low, starts no routine.
- R5: With bridge_en1 high, a one-cycle fs_err_seen pulse produces start_pulse with run_id 1 one cycle after the edge that samples it.
- R6: Bit k of host_req requests routine k+2. The request is kept pending while another routine runs and is served later.
- R7: Pending work is served one item at a time in a fixed order: routine 0, then 1, then 2, 3, 4 and 5, then the direct memory access.
- R8: While busy is high and done is low, busy stays high and no new start_pulse occurs.
- R9: On start_pulse, run_id is the routine number (0 to 5) and run_addr holds the value last written to that routine's start address register through cfg_we, cfg_idx and cfg_addr.
- R10: A pending host memory access (cam_req pulse) gives cam_gnt high for exactly one cycle, and only when no routine is busy or pending. cam_gnt is never high together with busy or start_pulse.
- R11: done clears busy at the edge that samples it. When the block is idle, done has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a start address register |
| cfg_idx | input | ID_W (3) | Routine whose start address is written |
| cfg_addr | input | ADDR_W (6) | Start address value to write |
| bridge_en0 | input | 1 | Enable for routine 0 |
| bridge_en1 | input | 1 | Enable for routine 1 |
| sd_delay | input | DELAY_W (4) | Cycles to wait after the start delimiter before routine 0 is armed |
| sd_seen | input | 1 | Start delimiter received (one-cycle pulse) |
| fs_err_seen | input | 1 | Frame status error indicator received (one-cycle pulse) |
| host_req | input | HOST_RT (4) | Host routine requests, bit k for routine k+2 |
| cam_req | input | 1 | Host direct memory access request |
| done | input | 1 | Running routine has finished |
| start_pulse | output | 1 | One-cycle routine start strobe |
| run_id | output | ID_W (3) | Number of the granted routine |
| run_addr | output | ADDR_W (6) | Entry address of the granted routine |
| busy | output | 1 | A routine is executing |
| cam_gnt | output | 1 | One-cycle direct memory access grant |

## Verification
On every cycle the assertions check the reset values, that a running routine is not preempted before done, that the granted address matches the start register of the granted routine, that a memory grant never coincides with routine activity, and that busy falls only after done. The service order, the trigger-to-start latencies with and without a delay, the restart of the delay count, and the effect of the enables can only be shown by the bench scenarios, which compare the outputs on every cycle against a behavioural model and also measure the latencies directly.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  // routines owned by the bridge unit (0 and 1); host routines follow them
  localparam int BRIDGE_RT = 2;
  typedef enum logic {ST_IDLE, ST_RUN} arb_state_e;
endpackage

// File: rtl/rsa_delay.sv
module rsa_delay #(
  parameter int DELAY_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic [DELAY_W-1:0] delay,
  output logic               fire
);
  logic [DELAY_W-1:0] cnt_q;
  logic               run_q;

  // a fresh trigger always overrides a running count
  assign fire = trig ? (delay == '0) : (run_q && cnt_q == DELAY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (trig) begin
      cnt_q <= delay;
      run_q <= (delay != '0);
    end else if (run_q) begin
      cnt_q <= cnt_q - DELAY_W'(1);
      if (cnt_q == DELAY_W'(1)) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rsa_pending.sv
module rsa_pending #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  // a new request on the same cycle as its grant stays pending
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | set;
  end
endmodule

// File: rtl/rsa_grant.sv
module rsa_grant #(
  parameter int NUM_RT = 6,
  parameter int ADDR_W = 6,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_RT:0]   pend,
  input  logic              done,
  input  logic [ADDR_W-1:0] start_addr [NUM_RT],
  output logic [NUM_RT:0]   clr,
  output logic              start_q,
  output logic [ID_W-1:0]   id_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              busy_q,
  output logic              cam_q
);
  import rsa_pkg::*;

  arb_state_e          st_q;
  logic                pick_ok;
  logic [ID_W-1:0]     pick;

  // lowest index wins; the memory access bit sits above all routines
  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int i = NUM_RT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick_ok = 1'b1;
        pick    = ID_W'(i);
      end
    end
    clr = '0;
    if (st_q == ST_IDLE) begin
      if (pick_ok)           clr[pick]   = 1'b1;
      else if (pend[NUM_RT]) clr[NUM_RT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      cam_q   <= 1'b0;
      id_q    <= '0;
      addr_q  <= '0;
    end else begin
      start_q <= 1'b0;
      cam_q   <= 1'b0;
      if (st_q == ST_RUN) begin
        if (done) st_q <= ST_IDLE;
      end else if (pick_ok) begin
        st_q    <= ST_RUN;
        start_q <= 1'b1;
        id_q    <= pick;
        addr_q  <= start_addr[pick];
      end else if (pend[NUM_RT]) begin
        cam_q <= 1'b1;
      end
    end
  end

  assign busy_q = (st_q == ST_RUN);
endmodule

// File: rtl/routine_start_arbiter.sv
module routine_start_arbiter #(
  parameter int ADDR_W  = 6,
  parameter int DELAY_W = 4,
  parameter int HOST_RT = 4,
  localparam int NUM_RT = rsa_pkg::BRIDGE_RT + HOST_RT,
  localparam int ID_W   = $clog2(NUM_RT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ID_W-1:0]    cfg_idx,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic               bridge_en0,
  input  logic               bridge_en1,
  input  logic [DELAY_W-1:0] sd_delay,
  input  logic               sd_seen,
  input  logic               fs_err_seen,
  input  logic [HOST_RT-1:0] host_req,
  input  logic               cam_req,
  input  logic               done,
  output logic               start_pulse,
  output logic [ID_W-1:0]    run_id,
  output logic [ADDR_W-1:0]  run_addr,
  output logic               busy,
  output logic               cam_gnt
);
  logic [ADDR_W-1:0] sa_q [NUM_RT];
  logic              fire0;
  logic [NUM_RT:0]   set_v;
  logic [NUM_RT:0]   clr_v;
  logic [NUM_RT:0]   pend_v;

  for (genvar g = 0; g < NUM_RT; g++) begin : g_sa
    always_ff @(posedge clk) begin
      if (rst)                                    sa_q[g] <= '0;
      else if (cfg_we && cfg_idx == ID_W'(g))     sa_q[g] <= cfg_addr;
    end
  end

  rsa_delay #(.DELAY_W(DELAY_W)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .trig  (sd_seen & bridge_en0),
    .delay (sd_delay),
    .fire  (fire0)
  );

  assign set_v = {cam_req, host_req, fs_err_seen & bridge_en1, fire0};

  rsa_pending #(.N(NUM_RT + 1)) u_pend (
    .clk  (clk),
    .rst  (rst),
    .set  (set_v),
    .clr  (clr_v),
    .pend (pend_v)
  );

  rsa_grant #(.NUM_RT(NUM_RT), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_grant (
    .clk        (clk),
    .rst        (rst),
    .pend       (pend_v),
    .done       (done),
    .start_addr (sa_q),
    .clr        (clr_v),
    .start_q    (start_pulse),
    .id_q       (run_id),
    .addr_q     (run_addr),
    .busy_q     (busy),
    .cam_q      (cam_gnt)
  );
endmodule

// File: rtl/rsa_checker.sv
module rsa_checker #(
  parameter int ADDR_W  = 6,
  parameter int HOST_RT = 4,
  localparam int NUM_RT = rsa_pkg::BRIDGE_RT + HOST_RT,
  localparam int ID_W   = $clog2(NUM_RT)
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              start_pulse,
  input logic [ID_W-1:0]   run_id,
  input logic [ADDR_W-1:0] run_addr,
  input logic              busy,
  input logic              cam_gnt,
  input logic [ADDR_W-1:0] sa [NUM_RT]
);
  logic [ADDR_W-1:0] sa_d [NUM_RT];
  always_ff @(posedge clk) sa_d <= sa;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !start_pulse && !cam_gnt));

  assert_no_preempt_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && !start_pulse));

  assert_start_addr_R9: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> (busy && run_id < ID_W'(NUM_RT) && run_addr == sa_d[run_id]));

  assert_cam_alone_R10: assert property (@(posedge clk) disable iff (rst)
    cam_gnt |-> (!busy && !start_pulse));

  assert_release_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done));
endmodule

bind routine_start_arbiter rsa_checker #(.ADDR_W(ADDR_W), .HOST_RT(HOST_RT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .done        (done),
  .start_pulse (start_pulse),
  .run_id      (run_id),
  .run_addr    (run_addr),
  .busy        (busy),
  .cam_gnt     (cam_gnt),
  .sa          (sa_q)
);

// File: tb/routine_start_arbiter_tb.sv
module routine_start_arbiter_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       cfg_we = 0;
  logic [2:0] cfg_idx = 0;
  logic [5:0] cfg_addr = 0;
  logic       en0 = 0, en1 = 0;
  logic [3:0] dly = 0;
  logic       sd = 0, fse = 0, cam_req = 0, done = 0;
  logic [3:0] hreq = 0;
  logic       start_pulse, busy, cam_gnt;
  logic [2:0] run_id;
  logic [5:0] run_addr;

  int total = 0, bad = 0;
  bit finished = 0, cmp_on = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  routine_start_arbiter u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
    .bridge_en0(en0), .bridge_en1(en1), .sd_delay(dly), .sd_seen(sd),
    .fs_err_seen(fse), .host_req(hreq), .cam_req(cam_req), .done(done),
    .start_pulse(start_pulse), .run_id(run_id), .run_addr(run_addr),
    .busy(busy), .cam_gnt(cam_gnt));

  function automatic int exp_addr(int i);
    return 8 + 7 * i;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int m_pend[7];
  int m_sa[6];
  int m_cnt, m_run, m_busy, m_start, m_cam, m_id, m_addr;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      foreach (m_sa[i]) m_sa[i] = 0;
      m_cnt = 0; m_run = 0; m_busy = 0; m_start = 0; m_cam = 0; m_id = 0; m_addr = 0;
    end else begin
      int g;
      int f0;
      m_start = 0; m_cam = 0;
      if (m_busy != 0) begin
        if (done) m_busy = 0;
      end else begin
        g = -1;
        for (int i = 0; i < 6; i++) if (m_pend[i] != 0 && g < 0) g = i;
        if (g >= 0) begin
          m_busy = 1; m_start = 1; m_id = g; m_addr = m_sa[g]; m_pend[g] = 0;
        end else if (m_pend[6] != 0) begin
          m_cam = 1; m_pend[6] = 0;
        end
      end
      f0 = 0;
      if (sd && en0) begin
        if (dly == 0) f0 = 1;
        else begin m_cnt = int'(dly); m_run = 1; end
      end else if (m_run != 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin f0 = 1; m_run = 0; end
      end
      if (f0 != 0) m_pend[0] = 1;
      if (fse && en1) m_pend[1] = 1;
      for (int k = 0; k < 4; k++) if (hreq[k]) m_pend[k+2] = 1;
      if (cam_req) m_pend[6] = 1;
      if (cfg_we && cfg_idx < 6) m_sa[cfg_idx] = int'(cfg_addr);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(busy == m_busy[0], {"model busy ", cur_req}, busy, m_busy);
      chk(start_pulse == m_start[0], {"model start ", cur_req}, start_pulse, m_start);
      chk(cam_gnt == m_cam[0], {"model cam_gnt ", cur_req}, cam_gnt, m_cam);
      chk(int'(run_id) == m_id, {"model run_id ", cur_req}, run_id, m_id);
      chk(int'(run_addr) == m_addr, {"model run_addr ", cur_req}, run_addr, m_addr);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sd();   sd = 1; tick(); sd = 0; endtask
  task automatic pulse_fse();  fse = 1; tick(); fse = 0; endtask
  task automatic release_rt(); done = 1; tick(); done = 0; endtask

  task automatic wait_start(output int lat);
    lat = 0;
    while (!start_pulse && lat < 40) begin tick(); lat++; end
  endtask

  task automatic wait_cam(output int lat);
    lat = 0;
    while (!cam_gnt && lat < 40) begin tick(); lat++; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lat;
    int none;
    tick(3);
    // R1: values during reset and just after
    chk(!busy && !start_pulse && !cam_gnt, "R1 flags in reset", busy, 0);
    rst = 0; cmp_on = 1;
    tick();
    chk(run_id == 0 && run_addr == 0 && !busy, "R1 after reset", run_addr, 0);

    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin
      cfg_we = 1; cfg_idx = 3'(i); cfg_addr = 6'(exp_addr(i)); tick();
    end
    cfg_we = 0;

    // R2: immediate routine 0
    cur_req = "R2";
    en0 = 1; en1 = 1; dly = 0;
    pulse_sd(); wait_start(lat);
    chk(lat == 1, "R2 latency", lat, 1);
    chk(run_id == 0, "R2 id", run_id, 0);
    chk(run_addr == 6'(exp_addr(0)), "R9 addr of routine 0", run_addr, exp_addr(0));
    cur_req = "R11";
    release_rt();
    chk(!busy, "R11 busy cleared by done", busy, 0);

    // R3: delayed start and restart of the count
    cur_req = "R3";
    dly = 5;
    pulse_sd(); wait_start(lat);
    chk(lat == 6, "R3 delay 5 latency", lat, 6);
    release_rt();
    pulse_sd(); tick(3); pulse_sd(); wait_start(lat);
    chk(lat == 6, "R3 restart latency", lat, 6);
    release_rt();
    dly = 0;

    // R4: disabled triggers are ignored
    cur_req = "R4";
    en0 = 0; en1 = 0;
    pulse_sd(); pulse_fse();
    none = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (start_pulse || busy) none++; end
    chk(none == 0, "R4 no start when disabled", none, 0);
    en0 = 1; en1 = 1;

    // R5: routine 1 on frame status error
    cur_req = "R5";
    pulse_fse(); wait_start(lat);
    chk(lat == 1 && run_id == 1, "R5 routine 1 start", run_id, 1);
    chk(run_addr == 6'(exp_addr(1)), "R9 addr of routine 1", run_addr, exp_addr(1));
    release_rt();

    // R6 / R8: host requests held while busy
    cur_req = "R6";
    hreq = 4'b0010; tick(); hreq = 0;
    wait_start(lat);
    chk(lat == 1 && run_id == 3, "R6 host routine 3", run_id, 3);
    hreq = 4'b1001; tick(); hreq = 0;
    cur_req = "R8";
    none = 0;
    for (int i = 0; i < 10; i++) begin tick(); if (start_pulse || !busy) none++; end
    chk(none == 0, "R8 held while busy", none, 0);
    release_rt(); wait_start(lat);
    chk(lat == 1 && run_id == 2, "R6 pending routine 2 served", run_id, 2);
    release_rt(); wait_start(lat);
    chk(lat == 1 && run_id == 5, "R6 pending routine 5 served", run_id, 5);
    chk(run_addr == 6'(exp_addr(5)), "R9 addr of routine 5", run_addr, exp_addr(5));
    release_rt();

    // R10: direct memory access when idle
    cur_req = "R10";
    cam_req = 1; tick(); cam_req = 0;
    wait_cam(lat);
    chk(lat == 1, "R10 cam grant latency", lat, 1);
    tick();
    chk(!cam_gnt, "R10 cam grant one cycle", cam_gnt, 0);

    // R11: done while idle has no effect
    cur_req = "R11";
    release_rt();
    none = 0;
    for (int i = 0; i < 4; i++) begin tick(); if (busy || start_pulse || cam_gnt) none++; end
    chk(none == 0, "R11 idle done ignored", none, 0);

    // R7: full service order
    cur_req = "R7";
    hreq = 4'b0010; tick(); hreq = 0;
    wait_start(lat);
    sd = 1; fse = 1; hreq = 4'b1111; cam_req = 1; tick();
    sd = 0; fse = 0; hreq = 0; cam_req = 0;
    tick(3);
    chk(!cam_gnt && busy, "R10 cam waits while busy", cam_gnt, 0);
    for (int k = 0; k < 6; k++) begin
      release_rt(); wait_start(lat);
      chk(lat == 1 && int'(run_id) == k, "R7 service order", run_id, k);
    end
    release_rt(); wait_cam(lat);
    chk(lat == 1, "R7 cam served last", lat, 1);
    tick(4);
    summary();
  end
endmodule